// File: doc/BRIEF.md
# Latched One-of-N Address Decoder

This block turns a small binary address into a single selected line out of `2**SEL_W` lines. The address first passes through a level-sensitive storage element. While the hold input is low, the element is transparent, so the decoder follows the address pins directly. While hold is high, the address seen just before hold rose is kept, and later address changes have no effect. This lets a shared address bus move on while the selection stays fixed.

Two enables of opposite sense gate every output: `en_i` is active high and `en_n_i` is active low. Both must be active for any line to be asserted. A parameter picks the output polarity. With `ACTIVE_LOW = 1`, the chosen line is driven low and the idle lines are high. With `ACTIVE_LOW = 0`, the chosen line is high and the idle lines are low. If one enable is held active and the other carries a data stream, the block works as a one-to-N demultiplexer, and the addressed line copies the data in the block's polarity.

Top module: `ldec_top`

## Requirements
- R1: With both enables active and hold low, exactly the line whose index equals the binary value of `sel_i` (bit 0 least significant) is asserted, for every address.
- R2: While `hold_i` is low, a change on `sel_i` moves the asserted line at once, with no clock involved.
- R3: While `hold_i` is high, the asserted line stays at the address present before hold rose, and changes on `sel_i` are ignored.
- R4: When `hold_i` falls, the outputs follow the current value of `sel_i` again.
- R5: When `en_n_i` is 1, every line is in its idle level, whatever the address and hold state.
- R6: When `en_i` is 0, every line is in its idle level, whatever the address and hold state.
- R7: With `ACTIVE_LOW = 1`, the asserted line is 0 and idle lines are 1. With `ACTIVE_LOW = 0`, the asserted line is 1 and idle lines are 0.
- R8: With one enable held active and the other toggled as data, the addressed line follows the data in the variant's polarity, and all other lines stay idle.
- R9: The enables do not gate the address storage. An address captured or followed while the outputs are disabled shows up once the enables become active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_i | input | SEL_W | Binary address, bit 0 least significant |
| hold_i | input | 1 | 1 keeps the stored address, 0 makes storage transparent |
| en_n_i | input | 1 | Active-low enable |
| en_i | input | 1 | Active-high enable |
| line_o | output | 2**SEL_W | Decoded lines in the polarity set by ACTIVE_LOW |

## Verification
A wrong stored address can only appear at the ports while hold is high. It shows as the wrong line asserted in the same settle step once the enables are active, or after the enables are re-enabled. A storage element that stays transparent shows up right away as the selected line following `sel_i` during hold. A gating fault shows as one or more lines leaving their idle level while an enable is inactive, with no delay. A polarity fault inverts all lines at once.

// File: rtl/ldec_pkg.sv
package ldec_pkg;
   // Largest supported address width; keeps the decoded vector modest.
   localparam int unsigned LDEC_MAX_SEL_W = 6;

   // Level a lane takes, given the polarity option and whether it is chosen.
   function automatic logic ldec_lane(input bit act_low, input logic chosen);
      return act_low ? ~chosen : chosen;
   endfunction
endpackage

// File: rtl/ldec_addr_hold.sv
module ldec_addr_hold #(
   parameter int unsigned SEL_W = 3
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic             hold_i,
   output logic [SEL_W-1:0] addr_o
);
   logic [SEL_W-1:0] addr_q;

   always_latch begin
      if (!hold_i) addr_q = sel_i;
   end

   assign addr_o = addr_q;

   // Transparent phase: stored address must track the pins.
   always_comb begin
      if (!hold_i) begin
         assert_transparent_R2: assert (addr_o == sel_i)
            else $error("storage not transparent while hold low");
      end
   end
endmodule

// File: rtl/ldec_onehot.sv
module ldec_onehot #(
   parameter int unsigned SEL_W = 3,
   localparam int unsigned N_OUT = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] addr_i,
   output logic [N_OUT-1:0] hot_o
);
   for (genvar g = 0; g < N_OUT; g++) begin : g_lane
      assign hot_o[g] = (addr_i == SEL_W'(g));
   end

   always_comb begin
      assert_onehot_R1: assert ($countones(hot_o) == 1)
         else $error("decoder output not one-hot");
   end
endmodule

// File: rtl/ldec_gate.sv
module ldec_gate #(
   parameter int unsigned N_OUT = 8,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic [N_OUT-1:0] hot_i,
   input  logic             en_n_i,
   input  logic             en_i,
   output logic [N_OUT-1:0] line_o
);
   import ldec_pkg::*;

   logic             pass;
   logic [N_OUT-1:0] chosen;

   assign pass   = en_i & ~en_n_i;
   assign chosen = hot_i & {N_OUT{pass}};

   if (ACTIVE_LOW) begin : g_low
      for (genvar g = 0; g < N_OUT; g++) begin : g_lane
         assign line_o[g] = ldec_lane(1'b1, chosen[g]);
      end
   end else begin : g_high
      for (genvar g = 0; g < N_OUT; g++) begin : g_lane
         assign line_o[g] = ldec_lane(1'b0, chosen[g]);
      end
   end
endmodule

// File: rtl/ldec_top.sv
module ldec_top #(
   parameter int unsigned SEL_W = 3,
   parameter bit ACTIVE_LOW = 1'b1,
   localparam int unsigned N_OUT = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic             hold_i,
   input  logic             en_n_i,
   input  logic             en_i,
   output logic [N_OUT-1:0] line_o
);
   import ldec_pkg::*;

   localparam logic [N_OUT-1:0] IDLE = ACTIVE_LOW ? '1 : '0;

   if (SEL_W < 1 || SEL_W > LDEC_MAX_SEL_W) begin : g_bad_width
      $error("ldec_top: SEL_W out of supported range");
   end

   logic [SEL_W-1:0] addr;
   logic [N_OUT-1:0] hot;

   ldec_addr_hold #(.SEL_W(SEL_W)) u_hold (
      .sel_i (sel_i),
      .hold_i(hold_i),
      .addr_o(addr)
   );

   ldec_onehot #(.SEL_W(SEL_W)) u_dec (
      .addr_i(addr),
      .hot_o (hot)
   );

   ldec_gate #(.N_OUT(N_OUT), .ACTIVE_LOW(ACTIVE_LOW)) u_gate (
      .hot_i (hot),
      .en_n_i(en_n_i),
      .en_i  (en_i),
      .line_o(line_o)
   );

   always_comb begin
      if (en_n_i) begin
         assert_idle_neg_R5: assert (line_o == IDLE)
            else $error("lines active with active-low enable off");
      end
      if (!en_i) begin
         assert_idle_pos_R6: assert (line_o == IDLE)
            else $error("lines active with active-high enable off");
      end
      assert_polarity_R7: assert ($countones(line_o ^ IDLE) <= 1)
         else $error("more than one line away from idle level");
      if (en_i && !en_n_i) begin
         assert_match_R1: assert (line_o == (IDLE ^ hot))
            else $error("enabled output differs from decoder choice");
      end
   end
endmodule

// File: tb/ldec_top_tb.sv
module ldec_top_tb;
   localparam int unsigned SEL_W = 3;
   localparam int unsigned N_OUT = 1 << SEL_W;

   typedef struct {
      logic [N_OUT-1:0] exp_lo;
      logic [N_OUT-1:0] exp_hi;
      string            req;
   } item_t;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [SEL_W-1:0] sel = '0;
   logic hold = 1'b0, en_n = 1'b0, en = 1'b1;
   logic [N_OUT-1:0] out_lo, out_hi;

   ldec_top #(.SEL_W(SEL_W), .ACTIVE_LOW(1'b1)) u_dut (
      .sel_i(sel), .hold_i(hold), .en_n_i(en_n), .en_i(en), .line_o(out_lo));
   ldec_top #(.SEL_W(SEL_W), .ACTIVE_LOW(1'b0)) u_dut_hi (
      .sel_i(sel), .hold_i(hold), .en_n_i(en_n), .en_i(en), .line_o(out_hi));

   item_t q[$];
   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;
   logic [SEL_W-1:0] m_addr = '0;

   // Driver: apply stimulus after a rising edge, queue the expectation.
   task automatic apply(input logic [SEL_W-1:0] s, input logic h,
                        input logic eb, input logic e, input string req);
      item_t it;
      logic [N_OUT-1:0] hot;
      @(posedge clk);
      sel = s; hold = h; en_n = eb; en = e;
      if (!h) m_addr = s;
      hot = (e && !eb) ? (N_OUT'(1) << m_addr) : '0;
      it.exp_hi = hot;
      it.exp_lo = ~hot;
      it.req = req;
      q.push_back(it);
   endtask

   // Monitor: compare on the falling edge, away from stimulus changes.
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         checks++;
         if (out_lo !== it.exp_lo) begin
            fails++;
            $display("FAIL %s low variant: got %b expected %b", it.req, out_lo, it.exp_lo);
         end
         checks++;
         if (out_hi !== it.exp_hi) begin
            fails++;
            $display("FAIL %s high variant: got %b expected %b", it.req, out_hi, it.exp_hi);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         fails++;
         $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // Open the storage first so it holds a known address.
      apply(3'd0, 1'b0, 1'b0, 1'b1, "R1 init");
      // R1 / R7: every address, both polarities.
      for (int a = 0; a < N_OUT; a++) apply(3'(a), 1'b0, 1'b0, 1'b1, "R1 R7 sweep");
      // R2: transparent tracking, descending order.
      for (int a = N_OUT - 1; a >= 0; a--) apply(3'(a), 1'b0, 1'b0, 1'b1, "R2 follow");
      // R3: capture 5, then wiggle sel.
      apply(3'd5, 1'b0, 1'b0, 1'b1, "R3 setup");
      apply(3'd5, 1'b1, 1'b0, 1'b1, "R3 capture");
      for (int a = 0; a < N_OUT; a++) apply(3'(a), 1'b1, 1'b0, 1'b1, "R3 ignore sel");
      // R4: release hold.
      apply(3'd2, 1'b0, 1'b0, 1'b1, "R4 release");
      apply(3'd6, 1'b0, 1'b0, 1'b1, "R4 follow again");
      // R5 / R6: all enable combinations across addresses and hold.
      for (int a = 0; a < N_OUT; a += 3) begin
         apply(3'(a), 1'b0, 1'b1, 1'b1, "R5 en_n off");
         apply(3'(a), 1'b0, 1'b0, 1'b0, "R6 en off");
         apply(3'(a), 1'b0, 1'b1, 1'b0, "R5 R6 both off");
         apply(3'(a), 1'b1, 1'b1, 1'b1, "R5 off in hold");
         apply(3'(a), 1'b1, 1'b0, 1'b0, "R6 off in hold");
         apply(3'(a), 1'b0, 1'b0, 1'b1, "R1 both on");
      end
      // R8: demux with en_n as data, then en as data.
      apply(3'd3, 1'b0, 1'b0, 1'b1, "R8 addr");
      apply(3'd3, 1'b1, 1'b0, 1'b1, "R8 hold addr");
      for (int k = 0; k < 6; k++) apply(3'd7, 1'b1, 1'(k % 2), 1'b1, "R8 data on en_n");
      for (int k = 0; k < 6; k++) apply(3'd1, 1'b1, 1'b0, 1'((k + 1) % 2), "R8 data on en");
      // R9: address moves while disabled, then enables return.
      apply(3'd4, 1'b0, 1'b1, 1'b0, "R9 track while off");
      apply(3'd4, 1'b1, 1'b1, 1'b0, "R9 capture while off");
      apply(3'd0, 1'b1, 1'b1, 1'b0, "R9 sel moves while off");
      apply(3'd0, 1'b1, 1'b0, 1'b1, "R9 re-enable shows captured");
      apply(3'd0, 1'b0, 1'b0, 1'b1, "R4 final release");
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule